// File: doc/BRIEF.md
# Prefetch Burst Serializer and Write Collector

This block sits between a wide memory core path and a narrow double-rate pin path. The core hands over one word of four beats (4n bits) every two external clocks. The pins move one n-bit beat on each half clock. Both external edges are modelled with a 2x clock (`clk2x`), so one `clk2x` cycle carries one beat.

On a read, a start pulse latches the first core word. The block then drives a one-clock preamble with the strobe low. After that it sends four beats per word, lowest-order beat first. The per-byte read strobes rise with the first beat and change level on every following beat, in step with the data. For a burst of eight, the block raises a one-cycle request during which it samples the second core word.

On a write, each byte lane has its own strobe. A lane takes in a beat of data and a mask bit whenever its strobe changes level. The strobe is centred on the data, so the beat is stable at that sample. After four beats the lanes present one assembled core word. A byte-enable vector goes with it, and each enable is the inverse of the mask bit that came with that byte.

Top module: `pf_burst_serdes`

## Requirements
- R1: After a synchronous active-low reset, `rd_oe`, `rd_dqs`, `rd_dq`, `rd_next` and `wr_valid` are all zero.
- R2: After `rd_go` is sampled while idle, the block spends two `clk2x` cycles in preamble. In those cycles `rd_oe` is 1, every `rd_dqs` bit is 0 and `rd_dq` is 0.
- R3: Beat k of a read word is `word[k*n +: n]`, so beats go out lowest-order first. Beat 0 appears in the third `clk2x` cycle after the cycle that sampled `rd_go`, and each later beat follows one cycle after the one before.
- R4: During read beats, every `rd_dqs` bit is 1 on even beats (0, 2, 4, 6) and 0 on odd beats. The strobe therefore changes level with each beat.
- R5: With `rd_bl8`=0 the burst has 4 beats. With `rd_bl8`=1 it has 8 beats, and `rd_next` is 1 only while beat 3 is shown. The block samples `rd_word` in that cycle and uses it as beats 4 to 7. After the last beat, `rd_oe` returns to 0.
- R6: A `rd_go` that arrives while a read burst is in progress has no effect. The running burst finishes with its own data and length.
- R7: A write lane captures `wr_dq` and `wr_dm` for its byte on each `clk2x` edge at which its `wr_dqs` bit differs from its value on the previous edge. After every fourth capture, `wr_valid` is 1 for one cycle. In that cycle beat k sits at `wr_word[k*n +: n]`, and lane b of beat k sits at byte b of that beat.
- R8: `wr_be` bit k*LANES+b is the inverse of the `wr_dm[b]` captured with beat k.
- R9: A write burst of eight beats gives two `wr_valid` words, in order of arrival.
- R10: While the write strobes hold their level, no beat is captured, whatever `wr_dq` does. A partial group of beats stays pending until later toggles complete it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the external rate, one beat per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_go | input | 1 | Start of a read burst |
| rd_bl8 | input | 1 | 1 selects an 8-beat read burst, 0 selects 4 |
| rd_word | input | 4*8*LANES | Core prefetch word, sampled at start and while `rd_next` is high |
| rd_next | output | 1 | Request for the second prefetch word of an 8-beat burst |
| rd_dq | output | 8*LANES | Read beat toward the pins |
| rd_dqs | output | LANES | Per-byte read strobes |
| rd_oe | output | 1 | Read drive enable, covers preamble and beats |
| wr_dqs | input | LANES | Per-byte write strobes |
| wr_dq | input | 8*LANES | Write beat from the pins |
| wr_dm | input | LANES | Per-byte write mask, 1 blocks the byte |
| wr_valid | output | 1 | One-cycle flag that an assembled write word is present |
| wr_word | output | 4*8*LANES | Assembled write word |
| wr_be | output | 4*LANES | Byte enables of the assembled word |

## Verification
Reads are run with both burst lengths and with word values whose beats all differ, so any swap of beat order or word order shows up. An eight-beat read uses a second word unlike the first, which shows whether the second fetch is sampled at the right cycle. Another read receives a stray start pulse mid-burst, which separates a restart from a clean finish. Writes use mixed mask patterns, a back-to-back eight-beat burst, and a burst broken by a long pause in which the data lines change while the strobes hold their level. That last case tells counting of strobe toggles apart from counting of cycles.

// File: rtl/pf_serdes_pkg.sv
// Shared definitions for the prefetch burst serializer.
// Assumes a byte is eight bits and a prefetch word holds four beats.
package pf_serdes_pkg;
    localparam int BYTE_W         = 8;
    localparam int BEATS_PER_WORD = 4;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_PRE  = 2'd1,
        RD_BEAT = 2'd2
    } rd_state_e;
endpackage

// File: rtl/pf_rd_serializer.sv
// Read serializer: takes one or two prefetch words and sends them out
// as single beats, one per clk2x cycle. A two-cycle preamble comes first.
// Assumes the second word is valid on `word` while `next_req` is high.
module pf_rd_serializer
    import pf_serdes_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      bl8,
    input  logic [4*BYTE_W*LANES-1:0] word,
    output logic                      next_req,
    output logic [BYTE_W*LANES-1:0]   dq,
    output logic [LANES-1:0]          dqs,
    output logic                      oe
);
    localparam int N = BYTE_W * LANES;
    localparam int W = BEATS_PER_WORD * N;

    rd_state_e      state_q;
    logic [2:0]     cnt_q;
    logic [W-1:0]   shreg_q;
    logic           long_q;
    logic [2:0]     last_beat;

    // last beat index for the latched burst length
    assign last_beat = long_q ? 3'd7 : 3'd3;

    // state, beat counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            long_q  <= 1'b0;
        end else begin
            case (state_q)
                RD_IDLE: begin
                    if (go) begin
                        state_q <= RD_PRE;
                        cnt_q   <= '0;
                        shreg_q <= word;
                        long_q  <= bl8;
                    end
                end
                RD_PRE: begin
                    if (cnt_q == 3'd1) begin
                        state_q <= RD_BEAT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 3'd1;
                    end
                end
                RD_BEAT: begin
                    if (next_req) shreg_q <= word;
                    else          shreg_q <= shreg_q >> N;
                    if (cnt_q == last_beat) begin
                        state_q <= RD_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 3'd1;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    // pin-side outputs, all taken from registers
    always_comb begin
        oe       = (state_q != RD_IDLE);
        dq       = (state_q == RD_BEAT) ? shreg_q[N-1:0] : '0;
        dqs      = {LANES{(state_q == RD_BEAT) && !cnt_q[0]}};
        next_req = (state_q == RD_BEAT) && long_q && (cnt_q == 3'd3);
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (dqs == '0) && (dq == '0) && !next_req);

    // R4
    strobe_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_BEAT) && (cnt_q != 3'd0) |-> dqs != $past(dqs));

    // R5
    next_then_beat4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        next_req |=> (state_q == RD_BEAT) && (cnt_q == 3'd4));

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_BEAT) && go |=> state_q != RD_PRE);
endmodule

// File: rtl/pf_wr_lane.sv
// Write collector for one byte lane. It captures a data byte and a mask
// bit on every level change of the lane strobe, and after four captures
// it flags a complete group for one cycle.
// Assumes the strobe is low after reset and each burst has an even
// number of toggles.
module pf_wr_lane
    import pf_serdes_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               dqs,
    input  logic [BYTE_W-1:0]                  dq,
    input  logic                               dm,
    output logic                               done,
    output logic [BEATS_PER_WORD-1:0][BYTE_W-1:0] bytes,
    output logic [BEATS_PER_WORD-1:0]          enables
);
    logic       prev_q;
    logic [1:0] cnt_q;
    logic       toggle;
    logic [BEATS_PER_WORD-1:0] mask_q;

    // a beat is present when the strobe level has changed
    assign toggle = dqs ^ prev_q;

    // strobe history, slot fill and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cnt_q  <= '0;
            bytes  <= '0;
            mask_q <= '0;
            done   <= 1'b0;
        end else begin
            prev_q <= dqs;
            done   <= toggle && (cnt_q == 2'd3);
            if (toggle) begin
                bytes[cnt_q]  <= dq;
                mask_q[cnt_q] <= dm;
                cnt_q         <= cnt_q + 2'd1;
            end
        end
    end

    // enables are the inverse of the captured mask bits
    assign enables = ~mask_q;

    // R7
    done_after_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(toggle) && ($past(cnt_q) == 2'd3));
endmodule

// File: rtl/pf_burst_serdes.sv
// Top level: a read serializer plus one write collector per byte lane.
// The assembled write word puts beat k at [k*N +: N] and lane b at
// byte b of that beat.
// Assumes the write strobes of all lanes arrive aligned to the same clk2x edge.
module pf_burst_serdes
    import pf_serdes_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                      clk2x,
    input  logic                      rst_n,
    input  logic                      rd_go,
    input  logic                      rd_bl8,
    input  logic [4*8*LANES-1:0]      rd_word,
    output logic                      rd_next,
    output logic [8*LANES-1:0]        rd_dq,
    output logic [LANES-1:0]          rd_dqs,
    output logic                      rd_oe,
    input  logic [LANES-1:0]          wr_dqs,
    input  logic [8*LANES-1:0]        wr_dq,
    input  logic [LANES-1:0]          wr_dm,
    output logic                      wr_valid,
    output logic [4*8*LANES-1:0]      wr_word,
    output logic [4*LANES-1:0]        wr_be
);
    localparam int N = BYTE_W * LANES;

    logic [LANES-1:0] lane_done;

    pf_rd_serializer #(.LANES(LANES)) rd_i (
        .clk      (clk2x),
        .rst_n    (rst_n),
        .go       (rd_go),
        .bl8      (rd_bl8),
        .word     (rd_word),
        .next_req (rd_next),
        .dq       (rd_dq),
        .dqs      (rd_dqs),
        .oe       (rd_oe)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [BEATS_PER_WORD-1:0][BYTE_W-1:0] lane_bytes;
        logic [BEATS_PER_WORD-1:0]             lane_en;

        pf_wr_lane lane_i (
            .clk     (clk2x),
            .rst_n   (rst_n),
            .dqs     (wr_dqs[b]),
            .dq      (wr_dq[b*BYTE_W +: BYTE_W]),
            .dm      (wr_dm[b]),
            .done    (lane_done[b]),
            .bytes   (lane_bytes),
            .enables (lane_en)
        );

        for (genvar k = 0; k < BEATS_PER_WORD; k++) begin : g_beat
            // place lane b of beat k in the assembled word
            assign wr_word[k*N + b*BYTE_W +: BYTE_W] = lane_bytes[k];
            assign wr_be[k*LANES + b]                = lane_en[k];
        end
    end

    // a word is complete when every lane has finished its group
    assign wr_valid = &lane_done;

    // R7
    lanes_aligned_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (|lane_done) |-> (&lane_done));

    // R7
    valid_single_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
endmodule

// File: tb/pf_burst_serdes_tb.sv
module pf_burst_serdes_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L = 2;
    localparam int N = 8 * L;
    localparam int W = 4 * N;

    logic clk2x = 1'b0;
    logic rst_n = 1'b0;
    logic rd_go = 1'b0, rd_bl8 = 1'b0;
    logic [W-1:0] rd_word = '0;
    logic rd_next, rd_oe;
    logic [N-1:0] rd_dq;
    logic [L-1:0] rd_dqs;
    logic [L-1:0] wr_dqs = '0;
    logic [N-1:0] wr_dq = '0;
    logic [L-1:0] wr_dm = '0;
    logic wr_valid;
    logic [W-1:0] wr_word;
    logic [4*L-1:0] wr_be;

    int total = 0, bad = 0, seen_words = 0, pushed_words = 0;
    logic [W-1:0]   exp_word_q[$];
    logic [4*L-1:0] exp_be_q[$];
    logic [N-1:0]   wb_data[4];
    logic [L-1:0]   wb_mask[4];
    int             wb_cnt = 0;

    always #(CLK_PERIOD/2) clk2x = ~clk2x;

    pf_burst_serdes #(.LANES(L)) dut_i (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver for reads: checks preamble, beats, strobe, request and end
    task automatic do_read(input logic [W-1:0] w0, input logic [W-1:0] w1,
                           input logic bl8, input logic stray_go);
        int nb;
        nb = bl8 ? 8 : 4;
        @(negedge clk2x);
        rd_go = 1'b1; rd_bl8 = bl8; rd_word = w0;
        @(negedge clk2x);
        rd_go = 1'b0; rd_bl8 = ~bl8; rd_word = w1;
        for (int p = 0; p < 2; p++) begin
            check("R2 oe", W'(rd_oe), W'(1));
            check("R2 dqs", W'(rd_dqs), W'(0));
            check("R2 dq", W'(rd_dq), W'(0));
            @(negedge clk2x);
        end
        for (int k = 0; k < nb; k++) begin
            logic [W-1:0] src;
            src = (k < 4) ? w0 : w1;
            check("R3 beat", W'(rd_dq), W'(src[(k%4)*N +: N]));
            check("R4 strobe", W'(rd_dqs), (k % 2 == 0) ? W'({L{1'b1}}) : W'(0));
            check("R5 next", W'(rd_next), W'(bl8 && k == 3));
            if (stray_go && k == 1) rd_go = 1'b1;
            else                    rd_go = 1'b0;
            if (stray_go && k == 1) rd_word = ~w0;
            @(negedge clk2x);
        end
        rd_go = 1'b0;
        check("R5 R6 oe after burst", W'(rd_oe), W'(0));
    endtask

    // driver for writes: one beat per call, pushes a word every fourth beat
    task automatic wr_beat(input logic [N-1:0] d, input logic [L-1:0] m);
        @(negedge clk2x);
        wr_dqs = ~wr_dqs; wr_dq = d; wr_dm = m;
        wb_data[wb_cnt] = d; wb_mask[wb_cnt] = m;
        wb_cnt++;
        if (wb_cnt == 4) begin
            logic [W-1:0] ew;
            logic [4*L-1:0] eb;
            for (int k = 0; k < 4; k++) begin
                ew[k*N +: N] = wb_data[k];
                eb[k*L +: L] = ~wb_mask[k];
            end
            exp_word_q.push_back(ew);
            exp_be_q.push_back(eb);
            pushed_words++;
            wb_cnt = 0;
        end
    endtask

    // monitor: pops expected write words as the design presents them
    always @(negedge clk2x) begin
        if (rst_n && wr_valid) begin
            seen_words++;
            if (exp_word_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 R10 unexpected word actual=%0h expected=none", wr_word);
            end else begin
                check("R7 R9 word", wr_word, exp_word_q.pop_front());
                check("R8 enables", W'(wr_be), W'(exp_be_q.pop_front()));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk2x);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 oe", W'(rd_oe), W'(0));
        check("R1 dqs", W'(rd_dqs), W'(0));
        check("R1 dq", W'(rd_dq), W'(0));
        check("R1 next", W'(rd_next), W'(0));
        check("R1 wr_valid", W'(wr_valid), W'(0));

        do_read(64'h4444_3333_2222_1111, 64'h0, 1'b0, 1'b0);
        do_read(64'hA1A2_B3B4_C5C6_D7D8, 64'h1357_2468_9ABC_DEF0, 1'b1, 1'b0);
        // R6 stray start during a 4-beat burst
        do_read(64'h0F0E_0D0C_0B0A_0908, 64'h0, 1'b0, 1'b1);
        repeat (2) @(negedge clk2x);
        check("R6 idle after stray go", W'(rd_oe), W'(0));

        // R7 R8 single word with mixed masks
        wr_beat(16'h1122, 2'b00);
        wr_beat(16'h3344, 2'b01);
        wr_beat(16'h5566, 2'b10);
        wr_beat(16'h7788, 2'b11);
        repeat (3) @(negedge clk2x);
        // R9 eight beats back to back
        for (int i = 0; i < 8; i++) wr_beat(16'(16'hA000 + i * 16'h0111), 2'(i % 3));
        repeat (3) @(negedge clk2x);
        // R10 partial group, pause with moving data, then completion
        wr_beat(16'hBEEF, 2'b00);
        wr_beat(16'hCAFE, 2'b10);
        wr_beat(16'hF00D, 2'b00);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk2x);
            wr_dq = 16'(i * 16'h1357); wr_dm = 2'(i);
        end
        check("R10 no word during pause", W'(seen_words), W'(3));
        wr_beat(16'hD00D, 2'b01);
        repeat (3) @(negedge clk2x);
        check("R9 R10 word count", W'(seen_words), W'(pushed_words));
        check("R9 queue drained", W'(exp_word_q.size()), W'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule